// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit count-up timers. They share one input clock and are reached over a simple synchronous register bus. Each channel has its own settings:

- a power-of-two prescaler,
- a counter that either runs freely or wraps at a programmable limit,
- a disable bit and a restart control,
- an interrupt line driven by a latched status bit and an enable bit.

Software uses one channel as a free-running timebase. It uses another as an event source that raises an interrupt each time the interval runs out, and clears the interrupt by reading the status register.

The registers are arranged in six groups. Within a group, channel n sits at the group offset plus 4*n. Writes take effect on the clock edge where the write strobe is high. A read returns data on `reg_rdata` one cycle after the read strobe.

Top module: `ttc_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low. With all registers at 0, every counter is enabled, prescaling is off, free-running mode is selected and interrupts are disabled.
- R2: Group offsets are:
  - 0x00 clock control,
  - 0x0C counter control,
  - 0x18 count (read-only),
  - 0x24 interval,
  - 0x54 status (read-only),
  - 0x60 interrupt enable.
  Channel n uses the group offset plus 4*n. `reg_rdata` is loaded on the edge where `reg_rd` is high and holds otherwise. An unmapped address reads 0.
- R3: In clock control, bit 0 turns the prescaler on and bits [4:1] hold N. With the prescaler on, the count advances once every 2^(N+1) clocks, so N=15 divides by 65536. With it off, the count advances every clock.
- R4: While counter control bit 0 is 1, the count holds its value.
- R5: Writing 1 to counter control bit 4 clears the count and the prescaler phase on that edge. This bit always reads 0. Bits 0, 1 and 5 are stored and read back. Bit 5 has no effect on counting.
- R6: When counter control bit 1 is 0, the count rolls over from 0xFFFF to 0 and never sets status.
- R7: When counter control bit 1 is 1, an advance taken at a count at or above the interval value returns the count to 0 and sets status bit 0. The period is therefore interval+1 advances.
- R8: A status read returns the status bits and clears them. If an interval event occurs on the same edge as the read, the event wins and the bit stays set.
- R9: `irq[n]` is high exactly when channel n's status bit 0 and enable bit 0 are both 1. Status still latches when the enable bit is 0.
- R10: Channels are independent: settings and events on one channel leave the other channels' registers and interrupts untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 3 | One interrupt line per channel |

## Verification
The bench builds the block with its default parameters: three channels, a 16-bit count and a 4-bit prescaler exponent. This makes the full 0xFFFF-to-0 rollover and the divide-by-65536 setting short enough to run end to end.

Small interval values, such as 5 and 3, make the wrap position, the interrupt timing and the edge where a status read meets a new event land on cycles the bench can predict. Using channel 2 alongside channel 0 shows that the per-channel address stride and the separate interrupt lines work.

// File: rtl/ttc_pkg.sv
// Shared constants for the three-channel timer: register group offsets,
// the per-channel stride and the bit positions decoded by the channels.
package ttc_pkg;

    localparam int NUM_GRP   = 6;
    localparam int CH_STRIDE = 4;

    // Register group indices
    localparam int GRP_CLK = 0;
    localparam int GRP_CNT = 1;
    localparam int GRP_VAL = 2;
    localparam int GRP_INT = 3;
    localparam int GRP_STS = 4;
    localparam int GRP_IEN = 5;

    // Field positions
    localparam int CLK_EN_BIT    = 0;
    localparam int CLK_EXP_LSB   = 1;
    localparam int CNT_DIS_BIT   = 0;
    localparam int CNT_MODE_BIT  = 1;
    localparam int CNT_RST_BIT   = 4;
    localparam int CNT_SPARE_BIT = 5;
    localparam int STS_IV_BIT    = 0;
    localparam int IEN_IV_BIT    = 0;

    // Byte offset of a register group for channel 0
    function automatic int grp_base(input int g);
        case (g)
            GRP_CLK: return 'h00;
            GRP_CNT: return 'h0C;
            GRP_VAL: return 'h18;
            GRP_INT: return 'h24;
            GRP_STS: return 'h54;
            GRP_IEN: return 'h60;
            default: return 'hFF;
        endcase
    endfunction

endpackage

// File: rtl/ttc_addr_decode.sv
// Address decoder: turns a byte address into a one-hot hit vector, one
// bit per (channel, register group). Assumes ADDR_W covers the top offset.
module ttc_addr_decode
    import ttc_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]                  addr,
    output logic [NUM_CH-1:0][NUM_GRP-1:0]     hit
);

    // One comparator per channel and register group
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            localparam int OFFS = grp_base(g) + CH_STRIDE * c;
            assign hit[c][g] = (addr == ADDR_W'(OFFS));
        end
    end

endmodule

// File: rtl/ttc_prescaler.sv
// Power-of-two prescaler: yields an advance tick every 2^(exp+1) clocks
// while enabled, or every clock while bypassed. Its phase is cleared by
// clr and it holds while run is low. Assumes 2^PRE_W fits a counter.
module ttc_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] exp_sel,
    input  logic             run,
    input  logic             clr,
    output logic             tick
);

    localparam int DIV_W = 2 ** PRE_W;

    logic [PRE_W:0]   shamt;
    logic [DIV_W-1:0] limit;
    logic [DIV_W-1:0] div_q;

    // Terminal divider value is 2^(exp+1)-1
    assign shamt = {1'b0, exp_sel} + {{PRE_W{1'b0}}, 1'b1};
    assign limit = ~({DIV_W{1'b1}} << shamt);

    // Tick when bypassed or when the divider reaches its limit
    assign tick = !en || (div_q == limit);

    // Divider phase: cleared on restart or bypass, advances while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr || !en) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= (div_q == limit) ? '0 : div_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/ttc_channel.sv
// One timer channel: control registers, prescaler, up-counter with
// free-running or interval wrap, clear-on-read status and interrupt
// gating. Assumes DATA_W >= CNT_W and DATA_W > CNT_SPARE_BIT.
module ttc_channel
    import ttc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [NUM_GRP-1:0] hit,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq
);

    logic             clk_en_q;
    logic [PRE_W-1:0] clk_exp_q;
    logic             dis_q, mode_q, spare_q;
    logic [CNT_W-1:0] intv_q, count_q;
    logic             ien_q, sts_q;

    logic wr_clk, wr_cnt, wr_int, wr_ien;
    logic restart_wr, sts_rd;
    logic tick, adv, at_top, iv_hit;
    logic unused_wdata;

    assign wr_clk     = wr_en && hit[GRP_CLK];
    assign wr_cnt     = wr_en && hit[GRP_CNT];
    assign wr_int     = wr_en && hit[GRP_INT];
    assign wr_ien     = wr_en && hit[GRP_IEN];
    assign restart_wr = wr_cnt && wdata[CNT_RST_BIT];
    assign sts_rd     = rd_en && hit[GRP_STS];
    assign unused_wdata = ^wdata;

    // Prescaler for this channel
    ttc_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (clk_en_q),
        .exp_sel (clk_exp_q),
        .run     (!dis_q),
        .clr     (restart_wr),
        .tick    (tick)
    );

    // Advance and interval-wrap decisions
    assign adv    = tick && !dis_q;
    assign at_top = mode_q && (count_q >= intv_q);
    assign iv_hit = adv && at_top && !restart_wr;

    // Clock control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en_q  <= 1'b0;
            clk_exp_q <= '0;
        end else if (wr_clk) begin
            clk_en_q  <= wdata[CLK_EN_BIT];
            clk_exp_q <= wdata[CLK_EXP_LSB +: PRE_W];
        end
    end

    // Counter control register (restart bit is not stored)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q   <= 1'b0;
            mode_q  <= 1'b0;
            spare_q <= 1'b0;
        end else if (wr_cnt) begin
            dis_q   <= wdata[CNT_DIS_BIT];
            mode_q  <= wdata[CNT_MODE_BIT];
            spare_q <= wdata[CNT_SPARE_BIT];
        end
    end

    // Interval and interrupt enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            intv_q <= '0;
            ien_q  <= 1'b0;
        end else begin
            if (wr_int) intv_q <= wdata[CNT_W-1:0];
            if (wr_ien) ien_q  <= wdata[IEN_IV_BIT];
        end
    end

    // Up-counter: restart first, then wrap or increment on an advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (restart_wr) begin
            count_q <= '0;
        end else if (adv) begin
            count_q <= at_top ? '0 : count_q + CNT_W'(1);
        end
    end

    // Status: a new event takes priority over a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= 1'b0;
        end else if (iv_hit) begin
            sts_q <= 1'b1;
        end else if (sts_rd) begin
            sts_q <= 1'b0;
        end
    end

    assign irq = sts_q && ien_q;

    // Read data for whichever register of this channel is addressed
    always_comb begin
        rdata = '0;
        if (hit[GRP_CLK]) begin
            rdata[CLK_EN_BIT]            = clk_en_q;
            rdata[CLK_EXP_LSB +: PRE_W]  = clk_exp_q;
        end
        if (hit[GRP_CNT]) begin
            rdata[CNT_DIS_BIT]   = dis_q;
            rdata[CNT_MODE_BIT]  = mode_q;
            rdata[CNT_SPARE_BIT] = spare_q;
        end
        if (hit[GRP_VAL]) rdata[CNT_W-1:0] = count_q;
        if (hit[GRP_INT]) rdata[CNT_W-1:0] = intv_q;
        if (hit[GRP_STS]) rdata[STS_IV_BIT] = sts_q;
        if (hit[GRP_IEN]) rdata[IEN_IV_BIT] = ien_q;
    end

    // R4: a disabled counter holds unless restarted
    a_r4_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q && !restart_wr) |=> $stable(count_q));

    // R5: a restart write leaves the count at zero
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart_wr |=> (count_q == '0));

    // R6: status only rises after an interval-mode cycle
    a_r6_free_no_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q) |-> $past(mode_q));

    // R7: an advance at or past the interval value returns the count to zero
    a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_top) |=> (count_q == '0));

    // R8: an event always leaves status set, even against a read
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        iv_hit |=> sts_q);

    // R8: a read with no event clears status
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && !iv_hit) |=> !sts_q);

endmodule

// File: rtl/ttc_timer.sv
// Three-channel timer top: decodes the register bus, fans strobes out to
// the channels, and returns registered read data one cycle after a read.
// Assumes a single clock domain and word-aligned byte addresses.
module ttc_timer
    import ttc_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic [NUM_CH-1:0][NUM_GRP-1:0] hit;
    logic [NUM_CH-1:0][DATA_W-1:0]  ch_rdata;
    logic [DATA_W-1:0]              rd_mux;

    // Address decode
    ttc_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_dec (
        .addr (reg_addr),
        .hit  (hit)
    );

    // Channel instances
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        ttc_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) i_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (reg_wr),
            .rd_en (reg_rd),
            .hit   (hit[c]),
            .wdata (reg_wdata),
            .rdata (ch_rdata[c]),
            .irq   (irq[c])
        );
    end

    // Merge channel read data (at most one channel is addressed)
    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) rd_mux |= ch_rdata[c];
    end

    // Registered read data, loaded only on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_mux;
        end
    end

    // R2: read data holds when no read is issued
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    // R2: an address never selects more than one register
    a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: tb/test_ttc_timer.sv
// Scoreboard bench: read tasks queue expected data, and a monitor pops the
// queue and compares against reg_rdata one cycle after each read.
module test_ttc_timer;

    localparam int CLK_PERIOD = 10;
    localparam int O_CLK = 'h00, O_CNT = 'h0C, O_VAL = 'h18;
    localparam int O_INT = 'h24, O_STS = 'h54, O_IEN = 'h60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  irq;

    int errors = 0;
    int checks = 0;
    logic rd_pend = 1'b0;
    logic [31:0] exp_q[$];
    string tag_q[$];

    ttc_timer i_ttc_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ra(input int grp, input int ch);
        return grp + 4 * ch;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input int addr, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 8'(addr); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_rd(input int addr, input logic [31:0] exp, input string tag);
        reg_rd = 1'b1; reg_addr = 8'(addr);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Monitor: note a read issued at this edge
    always @(posedge clk) rd_pend <= reg_rd;

    // Monitor: compare read data against the scoreboard
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check(reg_rdata, 32'hx, "R2 unexpected read data");
            end else begin
                check(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;

        // R1 reset values
        do_rd(ra(O_CLK, 0), 32'h0, "R1 clk ctrl reset");
        do_rd(ra(O_CNT, 0), 32'h0, "R1 cnt ctrl reset");
        do_rd(ra(O_INT, 0), 32'h0, "R1 interval reset");
        do_rd(ra(O_IEN, 0), 32'h0, "R1 enable reset");
        do_rd(ra(O_STS, 0), 32'h0, "R1 status reset");
        check({29'h0, irq}, 32'h0, "R1 irq reset");

        // R2 unmapped addresses
        do_rd('h40, 32'h0, "R2 unmapped 0x40");
        do_rd('h03, 32'h0, "R2 unmapped 0x03");

        // R5 readback of counter control, R4 hold
        do_wr(ra(O_CNT, 0), 32'h33);
        do_rd(ra(O_CNT, 0), 32'h23, "R5 cnt ctrl readback");
        idle(10);
        do_rd(ra(O_VAL, 0), 32'h0, "R4 count held while disabled");
        do_wr(ra(O_INT, 0), 32'hABCD);
        do_rd(ra(O_INT, 0), 32'hABCD, "R2 interval readback");
        do_wr(ra(O_IEN, 0), 32'h1);
        do_rd(ra(O_IEN, 0), 32'h1, "R2 enable readback");
        do_wr(ra(O_IEN, 0), 32'h0);
        do_wr(ra(O_CLK, 1), 32'h09);
        do_rd(ra(O_CLK, 1), 32'h09, "R10 ch1 clk ctrl readback");
        do_rd(ra(O_CLK, 0), 32'h0, "R10 ch0 clk ctrl untouched");
        do_wr(ra(O_CLK, 1), 32'h0);

        // R4 resume, R5 spare bit no effect
        do_wr(ra(O_CNT, 0), 32'h00);
        idle(9);
        do_rd(ra(O_VAL, 0), 32'd9, "R4 count after re-enable");
        do_wr(ra(O_CNT, 0), 32'h30);
        idle(9);
        do_rd(ra(O_VAL, 0), 32'd9, "R5 restart with spare bit");
        do_rd(ra(O_CNT, 0), 32'h20, "R5 restart bit reads 0");

        // R6 free-run rollover
        do_wr(ra(O_CNT, 0), 32'h10);
        idle(65535);
        do_rd(ra(O_VAL, 0), 32'hFFFF, "R6 count at top");
        do_rd(ra(O_VAL, 0), 32'h0, "R6 rollover to 0");
        do_rd(ra(O_STS, 0), 32'h0, "R6 no status in free mode");

        // R3 divide by 32
        do_wr(ra(O_CLK, 0), 32'h09);
        do_wr(ra(O_CNT, 0), 32'h10);
        idle(95);
        do_rd(ra(O_VAL, 0), 32'd2, "R3 div32 before tick");
        do_rd(ra(O_VAL, 0), 32'd3, "R3 div32 at tick");

        // R3 divide by 2048
        do_wr(ra(O_CLK, 0), 32'h15);
        do_wr(ra(O_CNT, 0), 32'h10);
        idle(2047);
        do_rd(ra(O_VAL, 0), 32'd0, "R3 div2048 before tick");
        do_rd(ra(O_VAL, 0), 32'd1, "R3 div2048 at tick");

        // R3 divide by 65536
        do_wr(ra(O_CLK, 0), 32'h1F);
        do_wr(ra(O_CNT, 0), 32'h10);
        idle(65535);
        do_rd(ra(O_VAL, 0), 32'd0, "R3 div65536 before tick");
        do_rd(ra(O_VAL, 0), 32'd1, "R3 div65536 at tick");

        // R5 restart clears prescaler phase
        do_wr(ra(O_CLK, 0), 32'h09);
        do_wr(ra(O_CNT, 0), 32'h10);
        idle(20);
        do_wr(ra(O_CNT, 0), 32'h10);
        idle(31);
        do_rd(ra(O_VAL, 0), 32'd0, "R5 phase reset before tick");
        do_rd(ra(O_VAL, 0), 32'd1, "R5 phase reset at tick");
        do_wr(ra(O_CLK, 0), 32'h0);

        // R7 interval mode, R8 clear-on-read, R9 gating
        do_wr(ra(O_INT, 0), 32'd5);
        do_wr(ra(O_IEN, 0), 32'h1);
        do_wr(ra(O_CNT, 0), 32'h12);
        idle(5);
        do_rd(ra(O_VAL, 0), 32'd5, "R7 count reaches interval");
        check({29'h0, irq}, 32'h1, "R9 irq after interval event");
        do_rd(ra(O_STS, 0), 32'h1, "R7 status set at wrap");
        do_rd(ra(O_STS, 0), 32'h0, "R8 status cleared by read");
        check({29'h0, irq}, 32'h0, "R9 irq low after clear");
        idle(3);
        do_rd(ra(O_STS, 0), 32'h0, "R8 read meets event");
        do_rd(ra(O_STS, 0), 32'h1, "R8 event wins over read");
        do_wr(ra(O_IEN, 0), 32'h0);
        idle(5);
        check({29'h0, irq}, 32'h0, "R9 irq gated by enable");
        do_rd(ra(O_STS, 0), 32'h1, "R9 status latched while gated");
        do_wr(ra(O_CNT, 0), 32'h01);

        // R10 channel 2 independent
        do_wr(ra(O_INT, 2), 32'd3);
        do_wr(ra(O_IEN, 2), 32'h1);
        do_wr(ra(O_CNT, 2), 32'h12);
        idle(7);
        do_rd(ra(O_VAL, 2), 32'd3, "R10 ch2 interval count");
        check({29'h0, irq}, 32'h4, "R10 only irq2 high");
        do_rd(ra(O_STS, 1), 32'h0, "R10 ch1 status clear");
        do_rd(ra(O_STS, 0), 32'h0, "R10 ch0 status clear");
        do_rd(ra(O_STS, 2), 32'h1, "R10 ch2 status set");

        idle(2);
        check(32'(exp_q.size()), 32'h0, "R2 all reads answered");
        summary();
        $finish;
    end

endmodule